// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. It combines two operands, a 5-bit operation code and an 8-bit immediate, and returns the 8-bit result in the same cycle. It also returns a result write enable and the value the status byte would take after the operation. A registered 8-bit status byte sits beside the combinational logic. It supplies the carry input and the T bit to the operations that use them. It captures the new flags on a clock edge when `exec` is high.

Every operation has its own mask of status bits it may change, and all other bits keep their stored value. The immediate has three uses: its low bits pick a bit position for the bit-transfer and flag set/clear operations, and the whole byte is the data when software loads the status byte directly. The top status bit is stored and returned, and the block does not act on it.

Top module: `alu8_flags`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0, I, T, H, S, V, N, Z, C. After reset it is 0x00. With `sreg_we` high it loads `imm` at the next edge, and this takes priority over `exec`. With `exec` high and `sreg_we` low it loads `flags_next` at the next edge. With both low it keeps its value.
- R2: ADD (op 0) and ADC (op 1, adds the stored C) write `a+b(+C)`. They update C, Z, N, V, S and H. C is the carry out of bit 7 and H is the carry out of bit 3. V is set on signed overflow. S is N XOR V. Z is set when the result is zero.
- R3: SUB (op 2), SBC (op 3, also subtracts the stored C) and NEG (op 12, computes `0x00-a`) update C, Z, N, V, S and H. C is the borrow out of bit 7. H is the borrow into bit 4. V is set on signed overflow.
- R4: CP (op 4, `a-b`) and CPC (op 5, `a-b-C`) set their flags by the subtraction rules, keep `result_we` low, and drive the difference on `result`.
- R5: For SBC and CPC, Z becomes 0 when the result is nonzero. When the result is zero, Z keeps its stored value.
- R6: AND (op 6), OR (op 7) and XOR (op 8) force V to 0. INC (op 9) sets V only for the input 0x7F, and DEC (op 10) sets V only for the input 0x80. All five update only Z, N, V and S, so H, C, T and I keep their values.
- R7: COM (op 11) writes `0xFF-a`, forces C to 1 and V to 0, updates Z, N and S, and leaves H unchanged.
- R8: LSL (op 13) fills bit 0 with 0 and moves bit 7 into C. LSR (op 14) fills bit 7 with 0 and moves bit 0 into C. ASR (op 17) keeps bit 7 and moves bit 0 into C. All three set V to N XOR the new C, update Z, N and S, and leave H unchanged.
- R9: ROL (op 15) moves the stored C into bit 0 and bit 7 into C. ROR (op 16) moves the stored C into bit 7 and bit 0 into C. V, S, Z and N follow the rule in R8.
- R10: SWAP (op 18) exchanges the two nibbles of `a` and changes no status bit.
- R11: BST (op 19) copies bit `imm[2:0]` of `a` into T and does not write a result. BLD (op 20) writes `a` with bit `imm[2:0]` replaced by T and changes no flag.
- R12: BSET (op 21) sets status bit `imm[2:0]` and BCLR (op 22) clears it. All other status bits keep their values, and no result is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 5 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| imm | input | 8 | Bit index in the low bits, or status load data |
| exec | input | 1 | Commit `flags_next` to the status byte |
| sreg_we | input | 1 | Load `imm` into the status byte |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_next | output | 8 | Status byte after this operation |
| sreg | output | 8 | Stored status byte |

## Verification
`result`, `result_we` and `flags_next` are combinational. They are due in the same cycle as the operands, so the bench drives on the falling edge and samples them a moment later, before any clock edge. The status byte passes through one register, so its new value is due one rising edge after `exec` or `sreg_we`. The bench checks it at the following falling edge. Each vector first loads a chosen starting status byte with `sreg_we`. This lets the stored-value cases (carry in, sticky Z, preserved H and T) start from known bits.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [7:0]   imm,
  input  logic         exec,
  input  logic         sreg_we,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [7:0]   flags_next,
  output logic [7:0]   sreg
);
  localparam int HB = W / 2;
  localparam int IW = $clog2(W);

  localparam logic [4:0] OP_ADD = 5'd0, OP_ADC = 5'd1, OP_SUB = 5'd2, OP_SBC = 5'd3;
  localparam logic [4:0] OP_CP = 5'd4, OP_CPC = 5'd5, OP_AND = 5'd6, OP_OR = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8, OP_INC = 5'd9, OP_DEC = 5'd10, OP_COM = 5'd11;
  localparam logic [4:0] OP_NEG = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15;
  localparam logic [4:0] OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWAP = 5'd18, OP_BST = 5'd19;
  localparam logic [4:0] OP_BLD = 5'd20, OP_BSET = 5'd21, OP_BCLR = 5'd22;

  logic         c_in, t_in;
  logic [W-1:0] x, y;
  logic         cy, sub;
  logic [W:0]   ar;
  logic [W-1:0] ar_r;
  logic         ar_h, ar_v;

  assign c_in = sreg[0];
  assign t_in = sreg[6];

  always_comb begin
    x = a; y = b; cy = 1'b0; sub = 1'b0;
    case (op)
      OP_ADC:         cy = c_in;
      OP_SUB, OP_CP:  sub = 1'b1;
      OP_SBC, OP_CPC: begin sub = 1'b1; cy = c_in; end
      OP_NEG:         begin x = '0; y = a; sub = 1'b1; end
      OP_INC:         y = W'(1);
      OP_DEC:         begin y = W'(1); sub = 1'b1; end
      default: ;
    endcase
  end

  assign ar   = sub ? ({1'b0, x} - {1'b0, y} - (W+1)'(cy)) : ({1'b0, x} + {1'b0, y} + (W+1)'(cy));
  assign ar_r = ar[W-1:0];
  assign ar_h = sub ? ((~x[HB-1] & y[HB-1]) | (y[HB-1] & ar_r[HB-1]) | (ar_r[HB-1] & ~x[HB-1]))
                    : ((x[HB-1] & y[HB-1]) | (y[HB-1] & ~ar_r[HB-1]) | (~ar_r[HB-1] & x[HB-1]));
  assign ar_v = sub ? ((x[W-1] & ~y[W-1] & ~ar_r[W-1]) | (~x[W-1] & y[W-1] & ar_r[W-1]))
                    : ((x[W-1] & y[W-1] & ~ar_r[W-1]) | (~x[W-1] & ~y[W-1] & ar_r[W-1]));

  logic [W-1:0] res;
  logic         we, fc, fv, ft, fz;
  logic [7:0]   mask, calc;

  always_comb begin
    res = a; we = 1'b0; mask = 8'h00; fc = c_in; fv = 1'b0; ft = t_in;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin res = ar_r; we = 1'b1; mask = 8'h3F; fc = ar[W]; fv = ar_v; end
      OP_CP, OP_CPC:   begin res = ar_r; mask = 8'h3F; fc = ar[W]; fv = ar_v; end
      OP_AND:          begin res = a & b; we = 1'b1; mask = 8'h1E; end
      OP_OR:           begin res = a | b; we = 1'b1; mask = 8'h1E; end
      OP_XOR:          begin res = a ^ b; we = 1'b1; mask = 8'h1E; end
      OP_INC, OP_DEC:  begin res = ar_r; we = 1'b1; mask = 8'h1E; fv = ar_v; end
      OP_COM:          begin res = ~a; we = 1'b1; mask = 8'h1F; fc = 1'b1; end
      OP_LSL:          begin res = {a[W-2:0], 1'b0};   fc = a[W-1]; end
      OP_LSR:          begin res = {1'b0, a[W-1:1]};   fc = a[0]; end
      OP_ROL:          begin res = {a[W-2:0], c_in};   fc = a[W-1]; end
      OP_ROR:          begin res = {c_in, a[W-1:1]};   fc = a[0]; end
      OP_ASR:          begin res = {a[W-1], a[W-1:1]}; fc = a[0]; end
      OP_SWAP:         begin res = {a[HB-1:0], a[W-1:HB]}; we = 1'b1; end
      OP_BST:          begin mask = 8'h40; ft = a[imm[IW-1:0]]; end
      OP_BLD:          begin res[imm[IW-1:0]] = t_in; we = 1'b1; end
      OP_BSET, OP_BCLR: mask = 8'h01 << imm[2:0];
      default: ;
    endcase
    if (op inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR}) begin
      we = 1'b1; mask = 8'h1F; fv = res[W-1] ^ fc;
    end
    fz = (res == '0);
    if (op == OP_SBC || op == OP_CPC) fz = fz & sreg[1];
    if (op == OP_BSET)      calc = 8'hFF;
    else if (op == OP_BCLR) calc = 8'h00;
    else calc = {sreg[7], ft, ar_h, res[W-1] ^ fv, fv, res[W-1], fz, fc};
  end

  assign result     = res;
  assign result_we  = we;
  assign flags_next = (sreg & ~mask) | (calc & mask);

  always_ff @(posedge clk) begin
    if (!rst_n)       sreg <= 8'h00;
    else if (sreg_we) sreg <= imm;
    else if (exec)    sreg <= flags_next;
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] op,
  input logic [7:0] imm,
  input logic       exec,
  input logic       sreg_we,
  input logic       result_we,
  input logic [7:0] flags_next,
  input logic [7:0] sreg
);
  assert_byte_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sreg_we |=> sreg == $past(imm));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sreg_we && !exec) |=> $stable(sreg));

  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd4 || op == 5'd5) |-> !result_we);

  assert_swap_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd18) |-> flags_next == sreg);

  assert_sign_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !sreg_we && op <= 5'd12) |=> sreg[4] == (sreg[2] ^ sreg[3]));

  assert_bset_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !sreg_we && op == 5'd21) |=> sreg[$past(imm[2:0])]);
endmodule

bind alu8_flags alu8_flags_chk chk (
  .clk(clk), .rst_n(rst_n), .op(op), .imm(imm), .exec(exec), .sreg_we(sreg_we),
  .result_we(result_we), .flags_next(flags_next), .sreg(sreg)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0, imm = '0;
  logic       exec = 1'b0, sreg_we = 1'b0;
  logic [7:0] result, flags_next, sreg;
  logic       result_we;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  alu8_flags uut (
    .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .imm(imm), .exec(exec),
    .sreg_we(sreg_we), .result(result), .result_we(result_we),
    .flags_next(flags_next), .sreg(sreg)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [4:0]  op;
    logic [7:0]  a, b, imm, init, r;
    logic        we;
    logic [7:0]  f;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{"R2 ", 5'd0,  8'h7F, 8'h01, 8'h00, 8'h00, 8'h80, 1'b1, 8'h2C},
    '{"R2 ", 5'd0,  8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 8'h23},
    '{"R2 ", 5'd1,  8'h10, 8'h20, 8'h00, 8'h01, 8'h31, 1'b1, 8'h00},
    '{"R2 ", 5'd1,  8'hFF, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 8'h23},
    '{"R3 ", 5'd2,  8'h10, 8'h01, 8'h00, 8'h00, 8'h0F, 1'b1, 8'h20},
    '{"R3 ", 5'd2,  8'h80, 8'h01, 8'h00, 8'h00, 8'h7F, 1'b1, 8'h38},
    '{"R3 ", 5'd3,  8'h05, 8'h05, 8'h00, 8'h01, 8'hFF, 1'b1, 8'h35},
    '{"R5 ", 5'd3,  8'h05, 8'h04, 8'h00, 8'h03, 8'h00, 1'b1, 8'h02},
    '{"R5 ", 5'd3,  8'h05, 8'h04, 8'h00, 8'h01, 8'h00, 1'b1, 8'h00},
    '{"R4 ", 5'd4,  8'h03, 8'h05, 8'h00, 8'h00, 8'hFE, 1'b0, 8'h35},
    '{"R5 ", 5'd5,  8'h00, 8'h00, 8'h00, 8'h03, 8'hFF, 1'b0, 8'h35},
    '{"R6 ", 5'd6,  8'hF0, 8'h3C, 8'h00, 8'h3F, 8'h30, 1'b1, 8'h21},
    '{"R6 ", 5'd7,  8'h80, 8'h01, 8'h00, 8'h08, 8'h81, 1'b1, 8'h14},
    '{"R6 ", 5'd8,  8'h55, 8'h55, 8'h00, 8'h00, 8'h00, 1'b1, 8'h02},
    '{"R6 ", 5'd9,  8'h7F, 8'h00, 8'h00, 8'h01, 8'h80, 1'b1, 8'h0D},
    '{"R6 ", 5'd10, 8'h80, 8'h00, 8'h00, 8'h20, 8'h7F, 1'b1, 8'h38},
    '{"R7 ", 5'd11, 8'h0F, 8'h00, 8'h00, 8'h20, 8'hF0, 1'b1, 8'h35},
    '{"R3 ", 5'd12, 8'h01, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h35},
    '{"R3 ", 5'd12, 8'h80, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1, 8'h0D},
    '{"R3 ", 5'd12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h02},
    '{"R8 ", 5'd13, 8'h81, 8'h00, 8'h00, 8'h00, 8'h02, 1'b1, 8'h19},
    '{"R8 ", 5'd14, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h1B},
    '{"R9 ", 5'd15, 8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 1'b1, 8'h19},
    '{"R9 ", 5'd16, 8'h02, 8'h00, 8'h00, 8'h01, 8'h81, 1'b1, 8'h0C},
    '{"R8 ", 5'd17, 8'h81, 8'h00, 8'h00, 8'h00, 8'hC0, 1'b1, 8'h15},
    '{"R10", 5'd18, 8'hA5, 8'h00, 8'h00, 8'h5A, 8'h5A, 1'b1, 8'h5A},
    '{"R11", 5'd19, 8'h08, 8'h00, 8'h03, 8'h00, 8'h08, 1'b0, 8'h40},
    '{"R11", 5'd19, 8'hF7, 8'h00, 8'h03, 8'hFF, 8'hF7, 1'b0, 8'hBF},
    '{"R11", 5'd20, 8'h00, 8'h00, 8'h05, 8'h40, 8'h20, 1'b1, 8'h40},
    '{"R11", 5'd20, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFE, 1'b1, 8'h00},
    '{"R12", 5'd21, 8'h00, 8'h00, 8'h07, 8'h00, 8'h00, 1'b0, 8'h80},
    '{"R12", 5'd22, 8'h00, 8'h00, 8'h01, 8'hFF, 8'h00, 1'b0, 8'hFD}
  };

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic load_sreg(input logic [7:0] v);
    @(negedge clk);
    sreg_we = 1'b1; imm = v; exec = 1'b0;
    @(negedge clk);
    sreg_we = 1'b0;
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1", "reset status", sreg, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      load_sreg(VEC[i].init);
      op = VEC[i].op; a = VEC[i].a; b = VEC[i].b; imm = VEC[i].imm;
      #1;
      if (VEC[i].we) check(string'(VEC[i].tag), "result", result, VEC[i].r);
      check(string'(VEC[i].tag), "result_we", {7'd0, result_we}, {7'd0, VEC[i].we});
      check(string'(VEC[i].tag), "flags_next", flags_next, VEC[i].f);
      exec = 1'b1;
      @(negedge clk);
      exec = 1'b0;
      #1 check(string'(VEC[i].tag), "stored flags", sreg, VEC[i].f);
    end

    load_sreg(8'h55);
    #1 check("R1", "byte load", sreg, 8'h55);
    op = 5'd0; a = 8'hFF; b = 8'h01;
    @(negedge clk);
    #1 check("R1", "hold without exec", sreg, 8'h55);

    sreg_we = 1'b1; exec = 1'b1; imm = 8'hA0;
    @(negedge clk);
    sreg_we = 1'b0; exec = 1'b0;
    #1 check("R1", "load wins over exec", sreg, 8'hA0);

    rst_n = 1'b0;
    @(negedge clk);
    #1 check("R1", "reset clears status", sreg, 8'h00);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule